// File: doc/BRIEF.md
# Nibble Receiver with Single-Error Correction

This block is the receive half of a serial link that protects each 4-bit payload with an 8-bit extended Hamming codeword. It idles until a low level is sampled on the serial input at a baud tick, which marks the start bit. It then takes one line bit per tick, for ten ticks. These are the eight codeword bits (least significant first), a marker bit that must be high, and a stop bit that must be high.

When the stop bit arrives, the codeword is decoded. A single flipped bit is repaired. Two flipped bits are reported as uncorrectable. The result is held for the processor. The processor sees a ready output. It answers with a one-cycle read strobe, which moves the nibble onto the data output. Status flags tell the processor whether the frame was clean, corrected, or uncorrectable. Further flags report a bad marker or stop bit, and data that was overwritten before it was read.

The baud tick comes from outside as a one-cycle pulse in the system clock domain. The block does no oversampling or rate generation.

Top module: `nibble_secded_rx`

## Requirements
- R1: After reset, ready, the data output and every status flag are 0, and the receiver is idle.
- R2: While idle, a baud tick with the serial input high starts nothing. A tick with the input low begins a frame.
- R3: After the start bit, one bit is taken per baud tick, in this order: codeword bits 0 to 7, then the marker, then the stop bit. Codeword bits 7:4 are the data d3..d0 and bits 3:0 are the check bits c3..c0.
- R4: The check equations are c0=d0^d1^d2, c1=d0^d1^d3 and c2=d0^d2^d3. c3 makes the parity of all eight bits even. A codeword that matches these raises only the clean flag, and its data is delivered as sent.
- R5: When exactly one data bit is flipped, the data is repaired and only the corrected flag is raised.
- R6: When exactly one check bit is flipped, including c3, the data passes unchanged and only the corrected flag is raised.
- R7: When two bits are flipped, only the uncorrectable flag is raised and the received data bits are delivered unchanged.
- R8: Ready and all status flags update in the clock cycle after the stop-bit tick, and ready rises at no other time.
- R9: A read strobe while ready is high puts the held nibble on the data output in the next cycle and clears ready. A strobe while ready is low changes nothing. The data output changes only on an accepted read.
- R10: A 0 in the marker or stop position raises the framing flag, and the frame is still decoded and reported.
- R11: A frame that completes while ready is still high and not being read raises the overrun flag, and the newer nibble replaces the older one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per serial bit time |
| rxd | input | 1 | Serial line, idle high |
| rd | input | 1 | Read strobe from the processor |
| dout | output | 4 | Corrected nibble, loaded on a read |
| ready | output | 1 | A decoded nibble is waiting |
| flag_ok | output | 1 | Last frame's codeword was clean |
| flag_fix | output | 1 | Last frame had one bit corrected |
| flag_dbl | output | 1 | Last frame had an uncorrectable double error |
| flag_frm | output | 1 | Last frame had a bad marker or stop bit |
| flag_ovr | output | 1 | Last frame overwrote unread data |

## Verification
The assertions assume that baud_tick is a single-cycle pulse and that rd lasts one cycle. They also assume that a line bit is held steady across the clock edge where its tick is sampled. The stimulus follows these rules. It sets each line bit several cycles before its tick, separates ticks by eight clocks, and issues a read as a one-cycle pulse between ticks.

Error injection flips at most two codeword bits per frame, because a triple error would alias to a single-bit correction. The reference model decodes by minimum Hamming distance over all sixteen nibbles rather than by syndrome. This makes it independent of the check-bit wiring.

// File: rtl/nibble_secded_rx.sv
module nibble_secded_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rxd,
  input  logic       rd,
  output logic [3:0] dout,
  output logic       ready,
  output logic       flag_ok,
  output logic       flag_fix,
  output logic       flag_dbl,
  output logic       flag_frm,
  output logic       flag_ovr
);
  localparam int NBITS = 10;
  localparam logic [3:0] LAST = 4'(NBITS - 1);

  logic       busy;
  logic [3:0] cnt;
  logic [8:0] sh;
  logic [3:0] hold;

  wire       done = baud_tick & busy & (cnt == LAST);
  wire       take = rd & ready;
  wire [7:0] cw   = sh[7:0];
  wire [3:0] d    = cw[7:4];
  wire [2:0] syn  = {cw[2] ^ d[0] ^ d[2] ^ d[3],
                     cw[1] ^ d[0] ^ d[1] ^ d[3],
                     cw[0] ^ d[0] ^ d[1] ^ d[2]};
  wire       odd  = ^cw;
  wire [3:0] flip = {odd & (syn == 3'd6), odd & (syn == 3'd5),
                     odd & (syn == 3'd3), odd & (syn == 3'd7)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      sh   <= '0;
      hold <= '0;
      dout <= '0;
      ready <= 1'b0;
      {flag_ok, flag_fix, flag_dbl, flag_frm, flag_ovr} <= '0;
    end else begin
      if (baud_tick) begin
        if (!busy) begin
          if (!rxd) begin
            busy <= 1'b1;
            cnt  <= '0;
          end
        end else begin
          sh  <= {rxd, sh[8:1]};
          cnt <= cnt + 4'd1;
          if (cnt == LAST) busy <= 1'b0;
        end
      end
      if (take) dout <= hold;
      if (done) begin
        hold     <= d ^ flip;
        flag_ok  <= ~odd & (syn == 3'd0);
        flag_fix <= odd;
        flag_dbl <= ~odd & (syn != 3'd0);
        flag_frm <= ~sh[8] | ~rxd;
        flag_ovr <= ready & ~rd;
        ready    <= 1'b1;
      end else if (take) begin
        ready <= 1'b0;
      end
    end
  end

  assert_ready_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(baud_tick && busy));
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && ready && !done) |=> !ready);
  assert_dout_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && ready) |=> $stable(dout));
  assert_one_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ($countones({flag_ok, flag_fix, flag_dbl}) == 1));
  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && baud_tick && rxd) |=> !busy);
  assert_overrun_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ovr) |-> $past(ready));
endmodule

// File: tb/tb_nibble_secded_rx.sv
module tb_nibble_secded_rx;
  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0, rxd = 1'b1, rd = 1'b0;
  logic [3:0] dout;
  logic ready, flag_ok, flag_fix, flag_dbl, flag_frm, flag_ovr;
  int compared = 0, mismatched = 0, cyc = 0;

  nibble_secded_rx dut (.clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd), .rd(rd),
    .dout(dout), .ready(ready), .flag_ok(flag_ok), .flag_fix(flag_fix), .flag_dbl(flag_dbl),
    .flag_frm(flag_frm), .flag_ovr(flag_ovr));

  always #2.5 clk = ~clk;

  function automatic logic [7:0] enc(input logic [3:0] d);
    logic c0, c1, c2, c3;
    c0 = d[0] ^ d[1] ^ d[2];
    c1 = d[0] ^ d[1] ^ d[3];
    c2 = d[0] ^ d[2] ^ d[3];
    c3 = ^{d, c2, c1, c0};
    return {d, c3, c2, c1, c0};
  endfunction

  // returns {ok, fix, dbl, data}
  function automatic logic [6:0] ref_dec(input logic [7:0] cw);
    for (int v = 0; v < 16; v++)
      if (enc(4'(v)) == cw) return {3'b100, 4'(v)};
    for (int v = 0; v < 16; v++)
      if ($countones(enc(4'(v)) ^ cw) == 1) return {3'b010, 4'(v)};
    return {3'b001, cw[7:4]};
  endfunction

  // behavioural reference
  int m_busy = 0, m_n = 0;
  logic [9:0] m_bits;
  logic [3:0] m_dout = 0, m_hold = 0;
  logic m_ready = 0, m_ok = 0, m_fix = 0, m_dbl = 0, m_frm = 0, m_ovr = 0;
  always @(posedge clk) begin
    logic took, was_ready;
    logic [6:0] r;
    if (!rst_n) begin
      m_busy = 0; m_n = 0; m_dout = 0; m_hold = 0; m_ready = 0;
      m_ok = 0; m_fix = 0; m_dbl = 0; m_frm = 0; m_ovr = 0;
    end else begin
      was_ready = m_ready;
      took = rd && m_ready;
      if (took) begin m_dout = m_hold; m_ready = 0; end
      if (baud_tick) begin
        if (m_busy == 0) begin
          if (rxd == 0) begin m_busy = 1; m_n = 0; end
        end else begin
          m_bits[m_n] = rxd;
          m_n++;
          if (m_n == 10) begin
            r = ref_dec(m_bits[7:0]);
            m_ok = r[6]; m_fix = r[5]; m_dbl = r[4]; m_hold = r[3:0];
            m_frm = !(m_bits[8] && m_bits[9]);
            m_ovr = was_ready && !took;
            m_ready = 1; m_busy = 0;
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R9 dout", dout, m_dout);
    chk("R8 ready", ready, m_ready);
    chk("R4 flag_ok", flag_ok, m_ok);
    chk("R5 flag_fix", flag_fix, m_fix);
    chk("R7 flag_dbl", flag_dbl, m_dbl);
    chk("R10 flag_frm", flag_frm, m_frm);
    chk("R11 flag_ovr", flag_ovr, m_ovr);
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      mismatched++;
      $display("FAIL watchdog R1..: actual=hung expected=done");
      summary();
    end
  end

  task automatic line_bit(input logic b);
    @(negedge clk) rxd = b;
    repeat (7) @(negedge clk);
    baud_tick = 1'b1;
    @(negedge clk) baud_tick = 1'b0;
  endtask

  task automatic frame(input logic [7:0] cw, input logic mk = 1'b1, input logic sp = 1'b1);
    line_bit(1'b0);
    for (int i = 0; i < 8; i++) line_bit(cw[i]);
    line_bit(mk);
    line_bit(sp);
    rxd = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_read();
    rd = 1'b1;
    @(negedge clk) rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready", ready, 0);
    chk("R1 dout", dout, 0);
    chk("R1 flags", {flag_ok, flag_fix, flag_dbl, flag_frm, flag_ovr}, 0);
    rst_n = 1'b1;
    // R2: idle-high ticks
    for (int i = 0; i < 4; i++) line_bit(1'b1);
    chk("R2 no frame", ready, 0);
    // R3: known vector
    frame(8'h17);
    chk("R3 ready", ready, 1);
    chk("R3 ok", flag_ok, 1);
    do_read();
    chk("R3 dout", dout, 1);
    chk("R9 ready cleared", ready, 0);
    // R9: strobe without ready
    do_read();
    chk("R9 no effect", dout, 1);
    // R4: all clean
    for (int v = 0; v < 16; v++) begin
      frame(enc(4'(v)));
      chk("R4 ok", flag_ok, 1);
      do_read();
      chk("R4 data", dout, v);
    end
    // R5 / R6: single flips
    for (int b = 0; b < 8; b++) begin
      frame(enc(4'hA) ^ (8'h01 << b));
      chk(b > 3 ? "R5 fix" : "R6 fix", flag_fix, 1);
      do_read();
      chk(b > 3 ? "R5 data" : "R6 data", dout, 4'hA);
    end
    // R7: double flips
    for (int b = 0; b < 7; b++) begin
      logic [7:0] bad;
      bad = enc(4'h6) ^ (8'h01 << b) ^ (8'h80 >> (6 - b));
      frame(bad);
      chk("R7 dbl", flag_dbl, 1);
      do_read();
      chk("R7 raw data", dout, bad[7:4]);
    end
    // R10: framing
    frame(enc(4'h3), 1'b1, 1'b0);
    chk("R10 stop", flag_frm, 1);
    do_read();
    chk("R10 data", dout, 3);
    frame(enc(4'h9), 1'b0, 1'b1);
    chk("R10 marker", flag_frm, 1);
    do_read();
    frame(enc(4'h9));
    chk("R10 clean", flag_frm, 0);
    do_read();
    // R11: overrun
    frame(enc(4'h5));
    frame(enc(4'hC));
    chk("R11 ovr", flag_ovr, 1);
    do_read();
    chk("R11 newest", dout, 4'hC);
    frame(enc(4'h2));
    chk("R11 cleared", flag_ovr, 0);
    do_read();
    repeat (4) @(negedge clk);
    summary();
  end
endmodule